// File: doc/BRIEF.md
# Oversampled Serial Receiver with Glitch Rejection

This block receives asynchronous serial characters from a single line that idles high. The line is sampled on a clock enable that pulses at sixteen times the bit rate. A falling edge seen on that enable begins a candidate start bit. The candidate is checked again near its centre. If the line is back high at that point, the candidate is treated as noise and dropped with no trace in the status. If the line is still low, the block samples one data bit per bit time, least significant bit first, and then samples the stop bit. It then copies the character into a holding register that the host can read.

A status byte reports whether a character is waiting, whether an unread character was lost, and whether the last stop bit was low. An interrupt request stays high while a character is waiting. The host clears data-ready with a read strobe for the holding register. It clears the two error flags with a separate read strobe for the status.

Top module: `uart_rx_core`

## Requirements
- R1: After reset `data_out` is 0, `rx_stat` is 0, and `data_ready`, `overrun`, `frame_err` and `rx_irq` are low.
- R2: The receiver samples `rx` only on clock cycles where `tick16` is high. A start is detected on the first such sample that is 0 after a sample of 1. The start is confirmed on the 7th tick after the detection tick. If that sample is 1, the frame is dropped and no output changes. A line low for 7 ticks is therefore ignored, and a line low for 8 ticks is accepted.
- R3: Data bits are sampled every 16 ticks, beginning 16 ticks after the confirmation tick. They are taken least significant bit first. The stop bit is sampled 16 ticks after the last data bit.
- R4: On the stop-bit sampling tick the assembled character appears on `data_out` and `data_ready` is set. `data_ready` is status bit 0 of `rx_stat`.
- R5: `rx_irq` is high exactly while `data_ready` is high. A one-cycle `rd_data` pulse clears both, unless a new character completes in the same cycle.
- R6: A stop bit sampled as 0 sets `frame_err` (status bit 3), and the character is still transferred.
- R7: A character that completes while `data_ready` is high overwrites `data_out` and sets `overrun` (status bit 1).
- R8: A one-cycle `rd_status` pulse clears `overrun` and `frame_err` and leaves `data_ready` unchanged. Status bits 2 and 7:4 always read 0.
- R9: After a stop bit sampled low, no new start is detected until the line has been sampled high at least once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Enable pulse at 16x the bit rate |
| rx | input | 1 | Serial line, idle high |
| rd_data | input | 1 | Host read strobe for the holding register |
| rd_status | input | 1 | Host read strobe for the status byte |
| data_out | output | 8 | Holding register |
| rx_stat | output | 8 | Status: bit0 ready, bit1 overrun, bit3 framing |
| data_ready | output | 1 | Character waiting |
| overrun | output | 1 | Unread character was overwritten |
| frame_err | output | 1 | Stop bit was sampled low |
| rx_irq | output | 1 | Receive-ready interrupt request |

## Verification
The assertions assume that `tick16` pulses for a single cycle and that at least four clock cycles separate pulses. This gives the two-stage line synchronizer time to settle before each sample. They also assume that `rd_data` and `rd_status` are single-cycle strobes. The bench produces a tick every fourth clock. It changes `rx` on the falling clock edge just after a tick and raises the read strobes only between ticks, so a read never coincides with a transfer.

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
  parameter int OVS   = 16,
  parameter int DBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick16,
  input  logic             rx,
  input  logic             rd_data,
  input  logic             rd_status,
  output logic [DBITS-1:0] data_out,
  output logic [7:0]       rx_stat,
  output logic             data_ready,
  output logic             overrun,
  output logic             frame_err,
  output logic             rx_irq
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DBITS + 1);
  localparam logic [CW-1:0] CONF_AT = CW'(OVS/2 - 2);
  localparam logic [CW-1:0] LAST    = CW'(OVS - 1);
  localparam logic [BW-1:0] NBITS   = BW'(DBITS);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    nbit;
  logic [DBITS-1:0] shreg;
  logic             rx_m, rx_s, rx_prev;
  logic             done;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rx;
      rx_s <= rx_m;
    end

  assign done = tick16 && (st == S_STOP) && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      nbit    <= '0;
      shreg   <= '0;
      rx_prev <= 1'b1;
    end else if (tick16) begin
      rx_prev <= rx_s;
      case (st)
        S_IDLE:
          if (rx_prev && !rx_s) begin
            st  <= S_START;
            cnt <= '0;
          end
        S_START:
          if (cnt == CONF_AT) begin
            cnt  <= '0;
            nbit <= '0;
            st   <= rx_s ? S_IDLE : S_DATA;
          end else
            cnt <= cnt + 1'b1;
        S_DATA:
          if (cnt == LAST) begin
            cnt   <= '0;
            shreg <= {rx_s, shreg[DBITS-1:1]};
            nbit  <= nbit + 1'b1;
            if (nbit == NBITS - 1'b1) st <= S_STOP;
          end else
            cnt <= cnt + 1'b1;
        S_STOP:
          if (cnt == LAST) begin
            cnt <= '0;
            st  <= S_IDLE;
          end else
            cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      data_out   <= '0;
      data_ready <= 1'b0;
      overrun    <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      if (rd_status) begin
        overrun   <= 1'b0;
        frame_err <= 1'b0;
      end
      if (rd_data) data_ready <= 1'b0;
      if (done) begin
        data_out   <= shreg;
        data_ready <= 1'b1;
        if (data_ready) overrun   <= 1'b1;
        if (!rx_s)      frame_err <= 1'b1;
      end
    end

  assign rx_stat = {4'b0000, frame_err, 1'b0, overrun, data_ready};
  assign rx_irq  = data_ready;
endmodule

module uart_rx_core_chk #(
  parameter int DBITS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick16,
  input logic             rd_data,
  input logic             rd_status,
  input logic [DBITS-1:0] data_out,
  input logic             data_ready,
  input logic             overrun,
  input logic             frame_err
);
  // R4
  ready_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_ready) |-> $past(tick16));
  // R4
  data_moves_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_out) |-> data_ready);
  // R5
  read_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !tick16) |=> !data_ready);
  // R7
  overrun_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(data_ready));
  // R8
  status_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && !tick16) |=> (!overrun && !frame_err));
  // R8
  status_read_keeps_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && !rd_data && !tick16) |=> $stable(data_ready));
endmodule

bind uart_rx_core uart_rx_core_chk #(.DBITS(DBITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick16(tick16), .rd_data(rd_data),
  .rd_status(rd_status), .data_out(data_out), .data_ready(data_ready),
  .overrun(overrun), .frame_err(frame_err)
);

// File: tb/tb_uart_rx_core.sv
module tb_uart_rx_core;
  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rx = 1'b1;
  logic rd_data = 1'b0, rd_status = 1'b0;
  logic [7:0] data_out, rx_stat;
  logic data_ready, overrun, frame_err, rx_irq;
  int errors = 0, checks = 0;

  uart_rx_core dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx(rx), .rd_data(rd_data),
    .rd_status(rd_status), .data_out(data_out), .rx_stat(rx_stat),
    .data_ready(data_ready), .overrun(overrun), .frame_err(frame_err),
    .rx_irq(rx_irq)
  );

  always #10 clk = ~clk;

  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % 4;
      tick16 = (ph == 0);
    end
  end

  // {data byte, stop bit, expected status}
  localparam logic [16:0] VEC [6] = '{
    {8'hA5, 1'b1, 8'h01}, {8'h00, 1'b1, 8'h01}, {8'hFF, 1'b1, 8'h01},
    {8'h3C, 1'b0, 8'h09}, {8'h81, 1'b1, 8'h01}, {8'h5A, 1'b0, 8'h09}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_tick();
    @(posedge clk iff tick16);
    @(negedge clk);
  endtask

  task automatic hold(input logic v, input int n);
    rx = v;
    for (int i = 0; i < n; i++) wait_tick();
  endtask

  task automatic send(input logic [7:0] d, input logic stopb);
    hold(1'b0, 16);
    for (int i = 0; i < 8; i++) hold(d[i], 16);
    hold(stopb, 16);
    hold(1'b1, 3);
  endtask

  task automatic pulse_data();
    rd_data = 1'b1; @(negedge clk); rd_data = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_status();
    rd_status = 1'b1; @(negedge clk); rd_status = 1'b0; @(negedge clk);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1
    chk("R1 data", data_out, 8'h00);
    chk("R1 stat", rx_stat, 8'h00);
    chk("R1 irq", {7'b0, rx_irq}, 8'h00);
    rst_n = 1'b1;
    hold(1'b1, 4);

    // R3 R4 R6 vectors
    for (int k = 0; k < 6; k++) begin
      send(VEC[k][16:9], VEC[k][8]);
      chk("R3 data", data_out, VEC[k][16:9]);
      chk(VEC[k][8] ? "R4 stat" : "R6 stat", rx_stat, VEC[k][7:0]);
      chk("R5 irq high", {7'b0, rx_irq}, 8'h01);
      pulse_data();
      pulse_status();
      chk("R5 cleared", {rx_stat[7:1], rx_irq}, 8'h00);
    end

    // R2 glitch of 7 ticks is dropped
    hold(1'b0, 7);
    hold(1'b1, 200);
    chk("R2 reject", rx_stat, 8'h00);
    chk("R2 reject irq", {7'b0, rx_irq}, 8'h00);

    // R2 low for 8 ticks is accepted, remaining bits read as 1
    hold(1'b0, 8);
    hold(1'b1, 200);
    chk("R2 accept data", data_out, 8'hFF);
    chk("R2 accept stat", rx_stat, 8'h01);
    pulse_data();

    // R7 overrun
    send(8'h11, 1'b1);
    send(8'h22, 1'b1);
    chk("R7 data", data_out, 8'h22);
    chk("R7 stat", rx_stat, 8'h03);
    // R8 status read keeps ready
    pulse_status();
    chk("R8 stat", rx_stat, 8'h01);
    // R5 data read
    pulse_data();
    chk("R5 stat", rx_stat, 8'h00);
    chk("R5 irq", {7'b0, rx_irq}, 8'h00);

    // R9 line stuck low after framing error
    hold(1'b0, 16);
    for (int i = 0; i < 8; i++) hold(1'b0, 16);
    hold(1'b0, 16);
    chk("R9 first", rx_stat, 8'h09);
    pulse_data();
    pulse_status();
    hold(1'b0, 300);
    chk("R9 no restart", rx_stat, 8'h00);
    hold(1'b1, 4);
    send(8'h6E, 1'b1);
    chk("R9 recover", data_out, 8'h6E);
    chk("R9 recover stat", rx_stat, 8'h01);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule